// File: doc/BRIEF.md
# Strobed Handshake Output Port

This block is a byte-wide output port that hands data to a peripheral under a two-wire handshake. The host writes a byte through a synchronous register interface. The byte is latched onto the port pins, and an active-low buffer-full line tells the peripheral that a byte is waiting. The peripheral takes the byte and pulls its active-low acknowledge line. That releases the buffer-full line.

When the peripheral lets acknowledge go again, the port can raise an interrupt request. The request tells the host that the next byte may be written. An internal enable bit gates it, and the next data write clears it.

A control register holds the interrupt enable and two spare general-purpose output lines. A status read lets the host observe the handshake state without using the interrupt.

Top module: `strobed_out_port`

## Requirements
- R1: After reset, obfN is 1, irq is 0, portData is all zeros, gpioOut is 0, and the interrupt enable is 0.
- R2: A write with hostAddr=0 latches hostWrData onto portData and drives obfN low at the next clock edge.
- R3: portData changes only on a data write (hostAddr=0). An acknowledge does not alter it, and neither does a control write.
- R4: The peripheral asserts ackN (low) while obfN is low. After ackN passes the SYNC_STAGES-flop synchronizer, obfN returns high no later than SYNC_STAGES+2 clock edges after ackN falls.
- R5: An acknowledge releases the buffer. When ackN later returns high, irq is set if the interrupt enable is 1. If the enable is 0, irq stays 0.
- R6: irq is cleared by the next data write. It is set only while obfN is high.
- R7: An acknowledge that arrives while obfN is high is ignored: obfN stays high and irq stays 0.
- R8: A write with hostAddr=1 stores the control byte. Bit 6 is the interrupt enable. Bit 5 drives gpioOut[1] and bit 4 drives gpioOut[0].
- R9: hostRdData shows the addressed register combinationally. With hostAddr=0 it shows the latched byte. With hostAddr=1 it shows status: bit 7 obfN, bit 6 enable, bit 5:4 gpioOut, bit 3 irq, and bits 2:0 zero.
- R10: A data write in the same cycle as a detected ackN fall wins. obfN stays low, the new byte is latched, and the following ackN rise raises no irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe, one cycle per write |
| hostAddr | input | 1 | Register select: 0 data, 1 control/status |
| hostWrData | input | DATA_W | Host write data |
| hostRdData | output | DATA_W | Read data of the addressed register |
| portData | output | DATA_W | Latched output byte to the peripheral |
| obfN | output | 1 | Buffer full, active low |
| ackN | input | 1 | Peripheral acknowledge, active low, asynchronous |
| irq | output | 1 | Ready-for-next-byte interrupt request |
| gpioOut | output | 2 | Spare general-purpose output lines |

## Verification
A lost or stuck "acknowledge taken" flag would show up at irq. Either irq would rise after an ignored acknowledge, or it would stay low after a genuine one, and in both cases this appears within SYNC_STAGES+2 edges of ackN going high. A corrupted buffer-full state would be seen on obfN and in status bit 7 one edge after the write or the synchronized acknowledge. A damaged latch would show on portData and on the data read at once.

// File: rtl/strobed_out_pkg.sv
package strobed_out_pkg;
  localparam int CTRL_INTEN_BIT = 6;
  localparam int CTRL_GPIO_LO   = 4;
  localparam int GPIO_W         = 2;
  localparam int STAT_OBF_BIT   = 7;
  localparam int STAT_IRQ_BIT   = 3;

  typedef struct packed {
    logic loadData;
    logic loadCtrl;
  } strobe_t;
endpackage

// File: rtl/strobed_out_sync.sv
module strobed_out_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rstN) chain[i] <= 1'b1;
        else if (i == 0) chain[i] <= asyncIn;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/strobed_out_ctrl.sv
module strobed_out_ctrl
  import strobed_out_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    hostWrEn,
  input  logic    hostAddr,
  input  logic    ackN,
  input  logic    intEnable,
  output strobe_t strobes,
  output logic    obfN,
  output logic    irq
);
  logic ackSync, ackPrev, ackFall, ackRise, ackTaken;

  strobed_out_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn(ackN), .syncOut(ackSync)
  );

  always_ff @(posedge clk) begin
    if (!rstN) ackPrev <= 1'b1;
    else       ackPrev <= ackSync;
  end

  assign ackFall = ackPrev & ~ackSync;
  assign ackRise = ~ackPrev & ackSync;

  always_comb begin
    strobes.loadData = hostWrEn & ~hostAddr;
    strobes.loadCtrl = hostWrEn &  hostAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      obfN     <= 1'b1;
      irq      <= 1'b0;
      ackTaken <= 1'b0;
    end else if (strobes.loadData) begin
      obfN     <= 1'b0;
      irq      <= 1'b0;
      ackTaken <= 1'b0;
    end else begin
      if (ackFall && !obfN) begin
        obfN     <= 1'b1;
        ackTaken <= 1'b1;
      end
      if (ackRise && ackTaken) begin
        ackTaken <= 1'b0;
        if (intEnable) irq <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/strobed_out_dpath.sv
module strobed_out_dpath
  import strobed_out_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic              hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              obfN,
  input  logic              irq,
  output logic [DATA_W-1:0] portData,
  output logic [DATA_W-1:0] hostRdData,
  output logic              intEnable,
  output logic [GPIO_W-1:0] gpioOut
);
  logic [DATA_W-1:0] status;

  always_ff @(posedge clk) begin
    if (!rstN) portData <= '0;
    else if (strobes.loadData) portData <= hostWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intEnable <= 1'b0;
      gpioOut   <= '0;
    end else if (strobes.loadCtrl) begin
      intEnable <= hostWrData[CTRL_INTEN_BIT];
      gpioOut   <= hostWrData[CTRL_GPIO_LO +: GPIO_W];
    end
  end

  always_comb begin
    status = '0;
    status[STAT_OBF_BIT]             = obfN;
    status[CTRL_INTEN_BIT]           = intEnable;
    status[CTRL_GPIO_LO +: GPIO_W]   = gpioOut;
    status[STAT_IRQ_BIT]             = irq;
    hostRdData = hostAddr ? status : portData;
  end
endmodule

// File: rtl/strobed_out_port.sv
module strobed_out_port
  import strobed_out_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic              hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  output logic [DATA_W-1:0] portData,
  output logic              obfN,
  input  logic              ackN,
  output logic              irq,
  output logic [1:0]        gpioOut
);
  strobe_t strobes;
  logic    intEnable;

  strobed_out_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .ackN(ackN), .intEnable(intEnable), .strobes(strobes),
    .obfN(obfN), .irq(irq)
  );

  strobed_out_dpath #(.DATA_W(DATA_W)) uDpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .obfN(obfN), .irq(irq),
    .portData(portData), .hostRdData(hostRdData),
    .intEnable(intEnable), .gpioOut(gpioOut)
  );
endmodule

// File: rtl/strobed_out_port_chk.sv
module strobed_out_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostWrEn,
  input logic              hostAddr,
  input logic [DATA_W-1:0] hostWrData,
  input logic [DATA_W-1:0] portData,
  input logic              obfN,
  input logic              irq,
  input logic [1:0]        gpioOut
);
  logic dataWr, ctrlWr;
  assign dataWr = hostWrEn && !hostAddr;
  assign ctrlWr = hostWrEn && hostAddr;

  // R2
  a_r2_write_latches: assert property (@(posedge clk) disable iff (!rstN)
    dataWr |=> (!obfN && portData == $past(hostWrData)));
  // R3
  a_r3_data_hold: assert property (@(posedge clk) disable iff (!rstN)
    !dataWr |=> $stable(portData));
  // R6
  a_r6_irq_clear: assert property (@(posedge clk) disable iff (!rstN)
    dataWr |=> !irq);
  // R6
  a_r6_irq_only_free: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> obfN);
  // R7
  a_r7_obf_falls_on_write: assert property (@(posedge clk) disable iff (!rstN)
    (obfN && !dataWr) |=> obfN);
  // R8
  a_r8_gpio_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWr |=> $stable(gpioOut));
endmodule

bind strobed_out_port strobed_out_port_chk #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
  .hostWrData(hostWrData), .portData(portData), .obfN(obfN),
  .irq(irq), .gpioOut(gpioOut)
);

// File: tb/strobed_out_port_test.sv
module strobed_out_port_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostWrEn = 1'b0;
  logic       hostAddr = 1'b0;
  logic [7:0] hostWrData = '0;
  logic [7:0] hostRdData, portData;
  logic       obfN, irq;
  logic       ackN = 1'b1;
  logic [1:0] gpioOut;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  strobed_out_port uut (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .portData(portData),
    .obfN(obfN), .ackN(ackN), .irq(irq), .gpioOut(gpioOut)
  );

  // vector: {ctrl byte, data byte}
  localparam logic [15:0] VEC [6] = '{
    16'h40_A5, 16'h00_3C, 16'h70_FF, 16'h10_00, 16'h60_81, 16'h20_5A
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    hostAddr = a;
    #0.5;
    d = hostRdData;
  endtask

  function automatic logic [7:0] status(logic o, logic [7:0] c, logic q);
    return {o, c[6], c[5:4], q, 3'b000};
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 obfN", {7'd0, obfN}, 8'd1);
    check("R1 irq", {7'd0, irq}, 8'd0);
    check("R1 portData", portData, 8'h00);
    check("R1 gpio", {6'd0, gpioOut}, 8'd0);
    rd(1'b1, r);
    check("R1 status", r, 8'h80);

    // R7: ack with nothing pending is ignored
    ackN = 1'b0; repeat (5) @(negedge clk);
    ackN = 1'b1; repeat (5) @(negedge clk);
    check("R7 obfN", {7'd0, obfN}, 8'd1);
    check("R7 irq", {7'd0, irq}, 8'd0);

    foreach (VEC[i]) begin
      logic [7:0] c, d;
      c = VEC[i][15:8]; d = VEC[i][7:0];
      wr(1'b1, c);
      check("R8 gpio", {6'd0, gpioOut}, {6'd0, c[5:4]});
      check("R3 data after ctrl write", portData, (i == 0) ? 8'h00 : VEC[i-1][7:0]);
      wr(1'b0, d);
      check("R2 portData", portData, d);
      check("R2 obfN", {7'd0, obfN}, 8'd0);
      check("R6 irq cleared", {7'd0, irq}, 8'd0);
      rd(1'b0, r);
      check("R9 data read", r, d);
      rd(1'b1, r);
      check("R9 status full", r, status(1'b0, c, 1'b0));
      ackN = 1'b0;
      repeat (4) @(negedge clk);
      check("R4 obfN released", {7'd0, obfN}, 8'd1);
      check("R5 no irq while ack low", {7'd0, irq}, 8'd0);
      ackN = 1'b1;
      repeat (4) @(negedge clk);
      check("R5 irq", {7'd0, irq}, {7'd0, c[6]});
      check("R3 data held", portData, d);
      rd(1'b1, r);
      check("R9 status free", r, status(1'b1, c, c[6]));
    end

    // R6: next data write clears a pending irq
    wr(1'b1, 8'h40);
    wr(1'b0, 8'h11);
    ackN = 1'b0; repeat (4) @(negedge clk);
    ackN = 1'b1; repeat (4) @(negedge clk);
    check("R6 irq set", {7'd0, irq}, 8'd1);
    wr(1'b0, 8'h22);
    check("R6 irq cleared by write", {7'd0, irq}, 8'd0);

    // R10: write collides with detected ack fall
    ackN = 1'b0;
    @(negedge clk); @(negedge clk);
    hostWrEn = 1'b1; hostAddr = 1'b0; hostWrData = 8'h77;
    @(negedge clk);
    hostWrEn = 1'b0;
    check("R10 obfN stays low", {7'd0, obfN}, 8'd0);
    check("R10 new data", portData, 8'h77);
    repeat (3) @(negedge clk);
    ackN = 1'b1; repeat (5) @(negedge clk);
    check("R10 no irq", {7'd0, irq}, 8'd0);
    check("R10 obfN still low", {7'd0, obfN}, 8'd0);

    // R1 again: reset mid-transfer
    rstN = 1'b0; @(negedge clk); rstN = 1'b1; @(negedge clk);
    check("R1 obfN after reset", {7'd0, obfN}, 8'd1);
    check("R1 portData after reset", portData, 8'h00);
    rd(1'b1, r);
    check("R1 enable after reset", r, 8'h80);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule